// File: doc/BRIEF.md
# Two-Slot Bypass Select and Hazard Control

This block is the operand-routing and hazard logic for an in-order integer pipeline that issues up to two instructions per cycle through five stages. It is purely combinational. It looks at the destination registers held in the two later pipeline registers: the one after execute (called M here) and the one after memory (called W here). Each holds two slots. From these it produces, for every ALU operand of both execute-stage slots, a 3-bit code that steers a five-input datapath mux. Four inputs are bypass sources and the fifth is the register-file value.

The block also serves a branch comparator that resolves the slot-0 branch during decode. It gives that comparator its own pair of select codes. It then looks at the decoding pair against the pair in execute and against itself. From that it decides among three actions:

- hold the whole pair;
- drop only the younger slot for one cycle, because of a load-use conflict;
- issue the pair split, because slot 1 reads a register that slot 0 of the same pair writes.

The datapath muxes, the register file, the ALU and the branch predictor live outside this block.

Top module: `dual_fwd_hazard`

## Requirements
- R1: Each select output uses the codes 0 = register file, 1 = M slot 0, 2 = M slot 1, 3 = W slot 0, 4 = W slot 1. A non-zero code names a producer whose destination equals the operand's register. When no producer matches, the code is 0.
- R2: When several producers match one operand, the youngest wins: M slot 1, then M slot 0, then W slot 1, then W slot 0.
- R3: A producer with write-enable low, or with destination register 0, never matches any operand.
- R4: A load sitting in W is bypassed to execute like any other result (code 3 or 4). It raises no hazard.
- R5: The two branch-comparator selects apply R1 to R3 to decode slot 0's rs1 and rs2.
- R6: `stall` rises when a valid decode slot 0 reads the enabled, non-zero destination of a load in either execute slot.
- R7: `stall` rises when a valid decode slot 0 is a branch and reads the enabled, non-zero destination of either execute slot, or of a load in either M slot.
- R8: `squash_s1` rises when a valid decode slot 1 reads the destination of a load in either execute slot. This happens only when neither `stall` nor `split_issue` is high.
- R9: `split_issue` rises when both decode slots are valid and slot 1 reads slot 0's enabled, non-zero destination, and `stall` is low. At most one of `stall`, `split_issue`, `squash_s1` is high.
- R10: An invalid decode slot raises no hazard of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 2 | decode slot valid flags, bit n for slot n |
| id_rs1 | input | 2x5 | decode rs1 per slot |
| id_rs2 | input | 2x5 | decode rs2 per slot |
| id_rd | input | 5 | decode slot 0 destination |
| id_we | input | 1 | decode slot 0 writes a register |
| id_is_branch | input | 1 | decode slot 0 is a conditional branch |
| ex_rs1 | input | 2x5 | execute rs1 per slot |
| ex_rs2 | input | 2x5 | execute rs2 per slot |
| ex_rd | input | 2x5 | execute destination per slot |
| ex_we | input | 2 | execute write-enable per slot |
| ex_load | input | 2 | execute slot is a load |
| mem_rd | input | 2x5 | M destination per slot |
| mem_we | input | 2 | M write-enable per slot |
| mem_load | input | 2 | M slot is a load |
| wb_rd | input | 2x5 | W destination per slot |
| wb_we | input | 2 | W write-enable per slot |
| ex_sel_a | output | 2x3 | rs1 bypass code per execute slot |
| ex_sel_b | output | 2x3 | rs2 bypass code per execute slot |
| br_sel_a | output | 3 | comparator rs1 bypass code |
| br_sel_b | output | 3 | comparator rs2 bypass code |
| stall | output | 1 | hold the decode pair, bubble into execute |
| squash_s1 | output | 1 | drop decode slot 1 for this cycle (load-use) |
| split_issue | output | 1 | issue slot 0 alone, slot 1 next cycle |

## Verification
The bench goes after the cases where all four producers name the same register. A design that ranked W above M, or slot 0 above slot 1, would hand an ALU stale data. It drives register 0 and disabled writers that collide with operands: a design that let them match would bypass garbage where the register file is right. It also builds decode pairs where a load conflict and an intra-pair dependency coincide, and branches that read an execute-stage or M-stage load result. A wrong precedence there would raise two controls at once, or let a branch compare a value that is not yet computed. Thousands of random collision patterns over a small register set cover the remaining combinations.

// File: rtl/fwd_pkg.sv
// Shared sizes and select codes for the two-slot bypass and hazard unit.
// Assumes two slots per stage and two bypass stages (M, W).
package fwd_pkg;
    localparam int REG_AW  = 5;
    localparam int NSLOT   = 2;
    localparam int NSTAGE  = 2;
    localparam int NPROD   = NSLOT * NSTAGE;
    localparam int SEL_W   = $clog2(NPROD + 1);

    // Code for producer (stage, slot); stage 0 is M, stage 1 is W.
    function automatic logic [SEL_W-1:0] src_code(input int stage, input int slot);
        return SEL_W'(stage * NSLOT + slot + 1);
    endfunction
endpackage

// File: rtl/fwd_operand.sv
// Bypass select for one consumer operand.
// Compares one source register against every producer and picks the youngest
// match. Producers are stage-major: index = stage*NSLOT + slot, with stage 0 the
// younger one. Assumes the caller packs producers in that order.
module fwd_operand
    import fwd_pkg::*;
#(
    parameter int AW   = REG_AW,
    parameter int NSL  = NSLOT,
    parameter int NST  = NSTAGE,
    localparam int NP  = NSL * NST,
    localparam int SW  = $clog2(NP + 1)
) (
    input  logic [AW-1:0]         rs,
    input  logic [NP-1:0][AW-1:0] prod_rd,
    input  logic [NP-1:0]         prod_we,
    output logic [SW-1:0]         sel
);
    logic [NP-1:0] hit;

    // one comparator per producer; x0 and disabled writers never hit
    for (genvar p = 0; p < NP; p++) begin : g_cmp
        assign hit[p] = prod_we[p] && (prod_rd[p] != '0) && (prod_rd[p] == rs);
    end

    // priority pick: walk oldest to youngest, the last hit seen wins
    always_comb begin
        sel = '0;
        for (int st = NST - 1; st >= 0; st--) begin
            for (int sl = 0; sl < NSL; sl++) begin
                if (hit[st*NSL + sl]) sel = SW'(st*NSL + sl + 1);
            end
        end
    end

    // guards: the chosen source really holds rs, and nothing younger also does
    always_comb begin
        if (sel != '0) begin
            // R1 R3
            sel_names_match_chk: assert (prod_we[int'(sel)-1] && prod_rd[int'(sel)-1] == rs && rs != '0)
                else $error("select names a producer that does not write rs");
            for (int q = 0; q < NP; q++) begin
                // R2
                sel_youngest_chk: assert (!(prod_we[q] && prod_rd[q] == rs &&
                    ((q / NSL) < ((int'(sel)-1) / NSL) ||
                     ((q / NSL) == ((int'(sel)-1) / NSL) && (q % NSL) > ((int'(sel)-1) % NSL)))))
                    else $error("a younger producer also matched");
            end
        end else begin
            for (int q = 0; q < NP; q++) begin
                // R1 R3
                sel_regfile_chk: assert (!(prod_we[q] && prod_rd[q] != '0 && prod_rd[q] == rs))
                    else $error("register file chosen though a producer matched");
            end
        end
    end
endmodule

// File: rtl/fwd_hazard.sv
// Decode-stage hazard decision for a two-slot pair.
// Decides hold-pair, drop-slot-1 (load-use) or split-issue (intra-pair RAW).
// Assumes a branch may sit only in decode slot 0 and that the comparator reads
// M and W through its own bypass selects.
module fwd_hazard
    import fwd_pkg::*;
#(
    parameter int AW  = REG_AW,
    parameter int NSL = NSLOT
) (
    input  logic [NSL-1:0]         id_valid,
    input  logic [NSL-1:0][AW-1:0] id_rs1,
    input  logic [NSL-1:0][AW-1:0] id_rs2,
    input  logic [AW-1:0]          id_rd,
    input  logic                   id_we,
    input  logic                   id_is_branch,
    input  logic [NSL-1:0][AW-1:0] ex_rd,
    input  logic [NSL-1:0]         ex_we,
    input  logic [NSL-1:0]         ex_load,
    input  logic [NSL-1:0][AW-1:0] mem_rd,
    input  logic [NSL-1:0]         mem_we,
    input  logic [NSL-1:0]         mem_load,
    output logic                   stall,
    output logic                   squash_s1,
    output logic                   split_issue
);
    // per consumer slot: reads an execute load / any execute writer / an M load
    logic [NSL-1:0] lu_hit;
    logic [NSL-1:0] ex_any_hit;
    logic [NSL-1:0] mem_ld_hit;
    logic           intra_dep;
    logic           stall_s0;

    // match every decode slot against every older producer
    for (genvar c = 0; c < NSL; c++) begin : g_cons
        logic [NSL-1:0] lu_v, exa_v, mld_v;
        for (genvar p = 0; p < NSL; p++) begin : g_prod
            logic ex_ok, mem_ok;
            assign ex_ok  = ex_we[p] && (ex_rd[p] != '0) &&
                            ((ex_rd[p] == id_rs1[c]) || (ex_rd[p] == id_rs2[c]));
            assign mem_ok = mem_we[p] && mem_load[p] && (mem_rd[p] != '0) &&
                            ((mem_rd[p] == id_rs1[c]) || (mem_rd[p] == id_rs2[c]));
            assign lu_v[p]  = ex_ok && ex_load[p];
            assign exa_v[p] = ex_ok;
            assign mld_v[p] = mem_ok;
        end
        assign lu_hit[c]     = id_valid[c] && (|lu_v);
        assign ex_any_hit[c] = id_valid[c] && (|exa_v);
        assign mem_ld_hit[c] = id_valid[c] && (|mld_v);
    end

    // slot 1 reads what slot 0 of the same pair writes
    assign intra_dep = (&id_valid) && id_we && (id_rd != '0) &&
                       ((id_rd == id_rs1[1]) || (id_rd == id_rs2[1]));

    // slot 0 cannot proceed: load-use, or branch operand not yet computed
    assign stall_s0 = lu_hit[0] || (id_is_branch && (ex_any_hit[0] || mem_ld_hit[0]));

    // precedence: hold pair > split issue > drop slot 1
    always_comb begin
        stall       = stall_s0;
        split_issue = !stall_s0 && intra_dep;
        squash_s1   = !stall_s0 && !intra_dep && lu_hit[1];
    end

    // guards on the control outputs
    always_comb begin
        // R9
        ctl_exclusive_chk: assert ($countones({stall, split_issue, squash_s1}) <= 1)
            else $error("more than one pipeline control raised");
        // R10
        stall_needs_s0_chk: assert (!stall || id_valid[0])
            else $error("stall from an invalid slot 0");
        // R10
        s1_needs_valid_chk: assert (!(squash_s1 || split_issue) || id_valid[1])
            else $error("slot 1 action on an invalid slot 1");
        // R6 R7
        stall_cause_chk: assert (!stall || (|(ex_we & ex_load)) || id_is_branch)
            else $error("stall without a load or branch cause");
    end
endmodule

// File: rtl/dual_fwd_hazard.sv
// Top of the two-slot bypass select and hazard unit.
// Builds a select for each execute ALU operand and for the decode branch
// comparator over the four M/W producers, and instantiates the hazard
// decision. Purely combinational; all timing is owned by the pipeline.
module dual_fwd_hazard
    import fwd_pkg::*;
#(
    parameter int AW  = REG_AW,
    localparam int SW = SEL_W
) (
    input  logic [NSLOT-1:0]         id_valid,
    input  logic [NSLOT-1:0][AW-1:0] id_rs1,
    input  logic [NSLOT-1:0][AW-1:0] id_rs2,
    input  logic [AW-1:0]            id_rd,
    input  logic                     id_we,
    input  logic                     id_is_branch,
    input  logic [NSLOT-1:0][AW-1:0] ex_rs1,
    input  logic [NSLOT-1:0][AW-1:0] ex_rs2,
    input  logic [NSLOT-1:0][AW-1:0] ex_rd,
    input  logic [NSLOT-1:0]         ex_we,
    input  logic [NSLOT-1:0]         ex_load,
    input  logic [NSLOT-1:0][AW-1:0] mem_rd,
    input  logic [NSLOT-1:0]         mem_we,
    input  logic [NSLOT-1:0]         mem_load,
    input  logic [NSLOT-1:0][AW-1:0] wb_rd,
    input  logic [NSLOT-1:0]         wb_we,
    output logic [NSLOT-1:0][SW-1:0] ex_sel_a,
    output logic [NSLOT-1:0][SW-1:0] ex_sel_b,
    output logic [SW-1:0]            br_sel_a,
    output logic [SW-1:0]            br_sel_b,
    output logic                     stall,
    output logic                     squash_s1,
    output logic                     split_issue
);
    logic [NPROD-1:0][AW-1:0] prod_rd;
    logic [NPROD-1:0]         prod_we;

    // pack producers stage-major: M slots first (younger), then W slots
    for (genvar s = 0; s < NSLOT; s++) begin : g_pack
        assign prod_rd[s]         = mem_rd[s];
        assign prod_we[s]         = mem_we[s];
        assign prod_rd[NSLOT + s] = wb_rd[s];
        assign prod_we[NSLOT + s] = wb_we[s];
    end

    // execute-stage operand selects, two per slot
    for (genvar s = 0; s < NSLOT; s++) begin : g_exsel
        fwd_operand #(.AW(AW), .NSL(NSLOT), .NST(NSTAGE)) u_op_a (
            .rs(ex_rs1[s]), .prod_rd(prod_rd), .prod_we(prod_we), .sel(ex_sel_a[s]));
        fwd_operand #(.AW(AW), .NSL(NSLOT), .NST(NSTAGE)) u_op_b (
            .rs(ex_rs2[s]), .prod_rd(prod_rd), .prod_we(prod_we), .sel(ex_sel_b[s]));
    end

    // decode branch comparator selects (slot 0 only)
    fwd_operand #(.AW(AW), .NSL(NSLOT), .NST(NSTAGE)) u_br_a (
        .rs(id_rs1[0]), .prod_rd(prod_rd), .prod_we(prod_we), .sel(br_sel_a));
    fwd_operand #(.AW(AW), .NSL(NSLOT), .NST(NSTAGE)) u_br_b (
        .rs(id_rs2[0]), .prod_rd(prod_rd), .prod_we(prod_we), .sel(br_sel_b));

    // decode hazard decision
    fwd_hazard #(.AW(AW), .NSL(NSLOT)) u_haz (
        .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rd(id_rd), .id_we(id_we), .id_is_branch(id_is_branch),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
        .stall(stall), .squash_s1(squash_s1), .split_issue(split_issue));
endmodule

// File: tb/dual_fwd_hazard_bench.sv
// Self-checking bench: directed corner cases, then random collision sweeps
// over a small register set, compared against a behavioural model every cycle.
module dual_fwd_hazard_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [1:0]      id_valid;
    logic [1:0][4:0] id_rs1, id_rs2;
    logic [4:0]      id_rd;
    logic            id_we, id_is_branch;
    logic [1:0][4:0] ex_rs1, ex_rs2, ex_rd;
    logic [1:0]      ex_we, ex_load;
    logic [1:0][4:0] mem_rd;
    logic [1:0]      mem_we, mem_load;
    logic [1:0][4:0] wb_rd;
    logic [1:0]      wb_we;
    logic [1:0][2:0] ex_sel_a, ex_sel_b;
    logic [2:0]      br_sel_a, br_sel_b;
    logic            stall, squash_s1, split_issue;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    dual_fwd_hazard u_dual_fwd_hazard (.*);

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // youngest-first search over M1, M0, W1, W0 (R1 R2 R3)
    function automatic int ref_sel(input logic [4:0] r);
        if (r == 0) return 0;
        if (mem_we[1] && mem_rd[1] == r) return 2;
        if (mem_we[0] && mem_rd[0] == r) return 1;
        if (wb_we[1]  && wb_rd[1]  == r) return 4;
        if (wb_we[0]  && wb_rd[0]  == r) return 3;
        return 0;
    endfunction

    function automatic bit reads(input int c, input logic [4:0] r);
        return r != 0 && (id_rs1[c] == r || id_rs2[c] == r);
    endfunction

    function automatic bit ex_load_read(input int c);
        bit f = 0;
        for (int p = 0; p < 2; p++) if (ex_we[p] && ex_load[p] && reads(c, ex_rd[p])) f = 1;
        return id_valid[c] && f;
    endfunction

    task automatic compare_all(input string tag);
        bit st, intra, lu1, brh;
        for (int s = 0; s < 2; s++) begin
            chk({tag, " R1 ex_sel_a"}, ex_sel_a[s], ref_sel(ex_rs1[s]));
            chk({tag, " R1 ex_sel_b"}, ex_sel_b[s], ref_sel(ex_rs2[s]));
        end
        chk({tag, " R5 br_sel_a"}, br_sel_a, ref_sel(id_rs1[0]));
        chk({tag, " R5 br_sel_b"}, br_sel_b, ref_sel(id_rs2[0]));
        brh = 0;
        for (int p = 0; p < 2; p++) begin
            if (ex_we[p] && reads(0, ex_rd[p])) brh = 1;
            if (mem_we[p] && mem_load[p] && reads(0, mem_rd[p])) brh = 1;
        end
        st    = ex_load_read(0) || (id_valid[0] && id_is_branch && brh);
        intra = id_valid[0] && id_valid[1] && id_we && reads(1, id_rd);
        lu1   = ex_load_read(1);
        chk({tag, " R6 R7 stall"}, stall, st);
        chk({tag, " R9 split"}, split_issue, !st && intra);
        chk({tag, " R8 squash"}, squash_s1, !st && !intra && lu1);
    endtask

    task automatic clear_in();
        id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_rd = 0; id_we = 0; id_is_branch = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0; ex_load = 0;
        mem_rd = 0; mem_we = 0; mem_load = 0; wb_rd = 0; wb_we = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        clear_in();
        step();
        // idle state: all zero inputs
        chk("R1 idle sel", ex_sel_a[0], 0);
        chk("R9 idle flags", {stall, split_issue, squash_s1}, 0);

        // R2: all four producers write x5
        @(posedge clk);
        mem_rd = {5'd5, 5'd5}; mem_we = 2'b11; wb_rd = {5'd5, 5'd5}; wb_we = 2'b11;
        ex_rs1[0] = 5; ex_rs2[1] = 5;
        step();
        chk("R2 M1 wins", ex_sel_a[0], 2);
        chk("R2 M1 wins b", ex_sel_b[1], 2);
        @(posedge clk); mem_we = 2'b01; step();
        chk("R2 M0 over W", ex_sel_a[0], 1);
        @(posedge clk); mem_we = 2'b00; step();
        chk("R2 W1 over W0", ex_sel_a[0], 4);
        @(posedge clk); wb_we = 2'b01; step();
        chk("R4 W0 select", ex_sel_a[0], 3);

        // R3: x0 and disabled writers never match
        @(posedge clk); clear_in(); mem_rd[1] = 0; mem_we = 2'b11; ex_rs1[0] = 0; step();
        chk("R3 x0 ignored", ex_sel_a[0], 0);
        @(posedge clk); mem_rd = {5'd7, 5'd7}; mem_we = 0; ex_rs1[0] = 7; step();
        chk("R3 we low ignored", ex_sel_a[0], 0);

        // R6: slot 0 load-use stall; R8 hidden by stall
        @(posedge clk); clear_in(); id_valid = 2'b11; ex_rd[1] = 9; ex_we[1] = 1; ex_load[1] = 1;
        id_rs2[0] = 9; id_rs1[1] = 9; step();
        chk("R6 load-use stall", stall, 1);
        chk("R8 masked by stall", squash_s1, 0);
        // R8: only slot 1 reads the load
        @(posedge clk); id_rs2[0] = 3; step();
        chk("R8 squash slot1", squash_s1, 1);
        chk("R8 no stall", stall, 0);
        // R9: intra-pair dep takes precedence over squash
        @(posedge clk); id_rd = 4; id_we = 1; id_rs2[1] = 4; step();
        chk("R9 split over squash", split_issue, 1);
        chk("R9 squash low", squash_s1, 0);
        // R10: invalid slot 1 raises nothing
        @(posedge clk); id_valid = 2'b01; step();
        chk("R10 invalid s1", {split_issue, squash_s1}, 0);

        // R7: branch reads a non-load in execute, then a load in M
        @(posedge clk); clear_in(); id_valid = 2'b01; id_is_branch = 1;
        ex_rd[0] = 6; ex_we[0] = 1; id_rs1[0] = 6; step();
        chk("R7 branch on ex result", stall, 1);
        @(posedge clk); ex_we = 0; mem_rd[0] = 6; mem_we[0] = 1; mem_load[0] = 1; step();
        chk("R7 branch on M load", stall, 1);
        chk("R5 br sel", br_sel_a, 1);
        @(posedge clk); mem_load = 0; step();
        chk("R7 M alu bypassed", stall, 0);
        // R10: invalid slot 0 never stalls
        @(posedge clk); mem_load[0] = 1; id_valid = 0; step();
        chk("R10 invalid s0", stall, 0);

        // random collision sweep over registers 0..3
        for (int n = 0; n < 8000; n++) begin
            @(posedge clk);
            id_valid = 2'($urandom_range(0, 3)) | 2'($urandom_range(0, 1));
            id_rd = 5'($urandom_range(0, 3)); id_we = 1'($urandom);
            id_is_branch = 1'($urandom);
            for (int s = 0; s < 2; s++) begin
                id_rs1[s] = 5'($urandom_range(0, 3)); id_rs2[s] = 5'($urandom_range(0, 3));
                ex_rs1[s] = 5'($urandom_range(0, 3)); ex_rs2[s] = 5'($urandom_range(0, 3));
                ex_rd[s]  = 5'($urandom_range(0, 3)); mem_rd[s] = 5'($urandom_range(0, 3));
                wb_rd[s]  = 5'($urandom_range(0, 3));
            end
            ex_we = 2'($urandom); ex_load = 2'($urandom);
            mem_we = 2'($urandom); mem_load = 2'($urandom); wb_we = 2'($urandom);
            step();
            compare_all("rand");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule